// File: doc/BRIEF.md
# Bidirectional Registered Bus Transceiver

This block joins two 18-bit ports, A and B, through two storage paths that work on their own: one carries A toward B and the other carries B toward A. Each path has one storage element that acts as either a latch or an edge-capture register. A per-direction latch enable picks the mode. While it is high the path is transparent. While it is low the path holds its value, and it loads a new value only on a rising edge of the direction's data strobe that the active-low clock enable lets through.

Each direction also has an active-low output enable. It drives an output-enable vector beside the port's output data, so the three-state behaviour can be checked without resolved nets. Every data input passes through a keeper. A bit that is marked as not driven repeats the last value it had while driven. The strobes are treated as data: they are sampled by the system clock, and a rising edge is found by comparing the strobe with its value in the previous cycle. A synchronous active-high reset clears both storage elements and both keepers.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: After reset, with latch enable low and no strobe edge, both path outputs read all zeros.
- R2: While a direction's latch enable is 1, its output equals its keeper-filtered input in the same cycle.
- R3: While latch enable is 0 and the strobe has no rising edge (strobe now 1, previous cycle 0), the output keeps its stored value whatever the input does.
- R4: With latch enable 0 and clock enable 0, the value at the input on a clock edge where the strobe rises is stored and appears at the output from the next cycle on.
- R5: With clock enable 1, strobe rising edges do not change the stored value.
- R6: When latch enable goes from 1 to 0, the output keeps the last value that passed through transparently.
- R7: Output enable low (0) sets every bit of that port's output-enable vector to 1; high (1) sets every bit to 0.
- R8: Storage keeps capturing while its output enable is high, and the output data shows the stored value.
- R9: The B-to-A path (b_in to a_out) behaves like the A-to-B path (a_in to b_out) under its own controls, and neither direction's controls affect the other.
- R10: A data bit whose drive flag is 0 reads as the value it had on the last clock edge where its drive flag was 1 (zero after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 18 | Data arriving at port A |
| a_drv | input | 18 | Per-bit flag: 1 when the a_in bit is actively driven |
| a_out | output | 18 | Data sent out on port A (B-to-A path) |
| a_oe | output | 18 | Port A output enable per bit |
| b_in | input | 18 | Data arriving at port B |
| b_drv | input | 18 | Per-bit flag: 1 when the b_in bit is actively driven |
| b_out | output | 18 | Data sent out on port B (A-to-B path) |
| b_oe | output | 18 | Port B output enable per bit |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable |
| ab_strb | input | 1 | A-to-B capture strobe |
| ab_clken_n | input | 1 | A-to-B clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable |
| ba_strb | input | 1 | B-to-A capture strobe |
| ba_clken_n | input | 1 | B-to-A clock enable, active low |

## Verification
Transparent data and the output-enable vectors respond in the cycle the stimulus is applied, with no clock edge needed. A capture shows at the output one cycle after the clock edge on which the rising strobe is first sampled. The keeper's held value likewise dates from the last edge on which the bit was driven. The bench applies inputs on the falling clock edge, compares the outputs 1 ns later against a model, and advances the model's stored, held and previous-strobe state once per rising edge. Transparent and registered results are therefore each checked in the cycle they are due.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int DEF_W = 18;
  localparam int N_DIR = 2;

  typedef struct packed {
    logic oe_n;
    logic le;
    logic strb;
    logic clken_n;
  } dir_ctrl_t;
endpackage

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pad_in,
  input  logic [W-1:0] pad_drv,
  output logic [W-1:0] eff
);
  logic [W-1:0] held_q;

  assign eff = (pad_drv & pad_in) | (~pad_drv & held_q);

  always_ff @(posedge clk) begin
    if (rst) held_q <= '0;
    else     held_q <= eff;
  end

  // undriven bits never change their held value
  assert_keep_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((held_q ^ $past(held_q)) & ~$past(pad_drv)) == '0));
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  dir_ctrl_t    ctrl,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] oe_vec
);
  logic [W-1:0] store_q;
  logic         strb_q;
  logic         rise;
  logic         cap;

  assign rise   = ctrl.strb & ~strb_q;
  assign cap    = ctrl.le | (rise & ~ctrl.clken_n);
  assign dout   = ctrl.le ? din : store_q;
  assign oe_vec = {W{~ctrl.oe_n}};

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
      strb_q  <= 1'b1;
    end else begin
      strb_q <= ctrl.strb;
      if (cap) store_q <= din;
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.le && !(ctrl.strb && !strb_q)) |=> $stable(store_q));

  assert_load_R4: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.le && ctrl.strb && !strb_q && !ctrl.clken_n) |=> (store_q == $past(din)));

  assert_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.le && ctrl.clken_n) |=> $stable(store_q));

  assert_track_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl.le |=> (store_q == $past(din)));
endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr
  import xcvr_pkg::*;
#(
  parameter int W = DEF_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] a_drv,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] b_drv,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  input  logic         ab_oe_n,
  input  logic         ab_le,
  input  logic         ab_strb,
  input  logic         ab_clken_n,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_strb,
  input  logic         ba_clken_n
);
  // index 0: A toward B, index 1: B toward A
  logic [W-1:0] src_in  [N_DIR];
  logic [W-1:0] src_drv [N_DIR];
  logic [W-1:0] src_eff [N_DIR];
  logic [W-1:0] dst_out [N_DIR];
  logic [W-1:0] dst_oe  [N_DIR];
  dir_ctrl_t    ctl     [N_DIR];

  assign src_in[0]  = a_in;
  assign src_drv[0] = a_drv;
  assign src_in[1]  = b_in;
  assign src_drv[1] = b_drv;
  assign ctl[0] = '{oe_n: ab_oe_n, le: ab_le, strb: ab_strb, clken_n: ab_clken_n};
  assign ctl[1] = '{oe_n: ba_oe_n, le: ba_le, strb: ba_strb, clken_n: ba_clken_n};

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    xcvr_keeper #(.W(W)) u_keep (
      .clk(clk), .rst(rst),
      .pad_in(src_in[d]), .pad_drv(src_drv[d]), .eff(src_eff[d])
    );
    xcvr_path #(.W(W)) u_path (
      .clk(clk), .rst(rst), .ctrl(ctl[d]),
      .din(src_eff[d]), .dout(dst_out[d]), .oe_vec(dst_oe[d])
    );
  end

  assign b_out = dst_out[0];
  assign b_oe  = dst_oe[0];
  assign a_out = dst_out[1];
  assign a_oe  = dst_oe[1];

  assert_oe_b_R7: assert property (@(posedge clk) disable iff (rst)
    (b_oe == '0) || (b_oe == '1));
  assert_oe_a_R7: assert property (@(posedge clk) disable iff (rst)
    (a_oe == '0) || (a_oe == '1));
endmodule

// File: tb/bidir_reg_xcvr_tb.sv
`timescale 1ns/1ps
module bidir_reg_xcvr_tb;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [W-1:0] din [2];
  logic [W-1:0] drv [2];
  logic oen [2], le [2], strb [2], cen [2];
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  // model state
  logic [W-1:0] m_held [2];
  logic [W-1:0] m_store [2];
  logic m_prev [2];

  int total = 0;
  int bad = 0;

  bidir_reg_xcvr #(.W(W)) u_dut (
    .clk(clk), .rst(rst),
    .a_in(din[0]), .a_drv(drv[0]), .a_out(a_out), .a_oe(a_oe),
    .b_in(din[1]), .b_drv(drv[1]), .b_out(b_out), .b_oe(b_oe),
    .ab_oe_n(oen[0]), .ab_le(le[0]), .ab_strb(strb[0]), .ab_clken_n(cen[0]),
    .ba_oe_n(oen[1]), .ba_le(le[1]), .ba_strb(strb[1]), .ba_clken_n(cen[1])
  );

  function automatic logic [W-1:0] eff_of(int d);
    return (drv[d] & din[d]) | (~drv[d] & m_held[d]);
  endfunction

  function automatic logic [W-1:0] exp_out(int d);
    return le[d] ? eff_of(d) : m_store[d];
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // inputs are set by the caller right after a falling edge
  task automatic step(string t0, string t1);
    logic [W-1:0] e;
    #1;
    if (!rst) begin
      chk(t0, b_out, exp_out(0));
      chk(t1, a_out, exp_out(1));
      chk("R7", b_oe, {W{~oen[0]}});
      chk("R7", a_oe, {W{~oen[1]}});
    end
    for (int d = 0; d < 2; d++) begin
      e = eff_of(d);
      if (rst) begin
        m_held[d] = '0; m_store[d] = '0; m_prev[d] = 1'b1;
      end else begin
        if (le[d] || (strb[d] && !m_prev[d] && !cen[d])) m_store[d] = e;
        m_held[d] = e;
        m_prev[d] = strb[d];
      end
    end
    @(negedge clk);
  endtask

  task automatic rnd_data();
    for (int d = 0; d < 2; d++) din[d] = W'($urandom);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int d = 0; d < 2; d++) begin
      din[d] = '0; drv[d] = '1; oen[d] = 1'b0; le[d] = 1'b0;
      strb[d] = 1'b0; cen[d] = 1'b1;
      m_held[d] = '0; m_store[d] = '0; m_prev[d] = 1'b1;
    end
    @(negedge clk);
    rnd_data();
    step("R1", "R1");
    step("R1", "R1");
    rst = 1'b0;
    rnd_data();
    step("R1", "R1");

    // R2 transparent
    le[0] = 1'b1; le[1] = 1'b1;
    for (int i = 0; i < 4; i++) begin rnd_data(); step("R2", "R2"); end

    // R6 falling latch enable keeps last value; R3 hold without edge
    le[0] = 1'b0; le[1] = 1'b0; rnd_data();
    step("R6", "R6");
    for (int i = 0; i < 3; i++) begin rnd_data(); step("R3", "R3"); end

    // R4 enabled capture
    cen[0] = 1'b0; cen[1] = 1'b0;
    for (int i = 0; i < 3; i++) begin
      rnd_data(); strb[0] = 1'b1; strb[1] = 1'b1; step("R4", "R4");
      rnd_data(); strb[0] = 1'b0; strb[1] = 1'b0; step("R4", "R4");
    end
    // strobe held high: no further capture
    strb[0] = 1'b1; strb[1] = 1'b1; rnd_data(); step("R4", "R4");
    rnd_data(); step("R3", "R3");
    strb[0] = 1'b0; strb[1] = 1'b0; rnd_data(); step("R3", "R3");

    // R5 blocked capture
    cen[0] = 1'b1; cen[1] = 1'b1;
    for (int i = 0; i < 3; i++) begin
      rnd_data(); strb[0] = 1'b1; strb[1] = 1'b1; step("R5", "R5");
      rnd_data(); strb[0] = 1'b0; strb[1] = 1'b0; step("R5", "R5");
    end

    // R8 capture while outputs disabled
    oen[0] = 1'b1; oen[1] = 1'b1; cen[0] = 1'b0; cen[1] = 1'b0;
    for (int i = 0; i < 3; i++) begin
      rnd_data(); strb[0] = 1'b1; strb[1] = 1'b1; step("R8", "R8");
      rnd_data(); strb[0] = 1'b0; strb[1] = 1'b0; step("R8", "R8");
    end
    oen[0] = 1'b0; oen[1] = 1'b0; step("R8", "R8");

    // R9 only A-to-B active, B-to-A quiet and latched
    cen[1] = 1'b1;
    for (int i = 0; i < 6; i++) begin
      rnd_data(); le[0] = i[0]; strb[0] = i[1]; oen[0] = i[2];
      step("R9", "R9");
    end
    le[0] = 1'b0; strb[0] = 1'b0; oen[0] = 1'b0; cen[1] = 1'b0;

    // R10 keeper with partial drive, seen through transparent paths
    le[0] = 1'b1; le[1] = 1'b1;
    din[0] = 18'h3ffff; din[1] = 18'h2aaaa; step("R10", "R10");
    drv[0] = 18'h000ff; drv[1] = 18'h0f0f0;
    din[0] = '0; din[1] = 18'h15555; step("R10", "R10");
    drv[0] = '0; drv[1] = '0; rnd_data(); step("R10", "R10");
    rnd_data(); step("R10", "R10");
    drv[0] = '1; drv[1] = '1;

    // random mix
    for (int i = 0; i < 400; i++) begin
      rnd_data();
      for (int d = 0; d < 2; d++) begin
        drv[d] = (($urandom % 4) == 0) ? W'($urandom) : '1;
        le[d] = (($urandom % 4) == 0);
        strb[d] = $urandom % 2;
        cen[d] = (($urandom % 3) == 0);
        oen[d] = $urandom % 2;
      end
      step("R4", "R9");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule